// File: doc/BRIEF.md
# Boost Fault Supervisor with Automatic Restart

This block is the digital supervisor beside a boost-mode power stage. It takes fault inputs that are already conditioned: bus over-voltage, soft-start failure, current limit, battery undervoltage, thermal shutdown and control-timer expiry. While the stage is running, any qualified fault has the same effect. The stage goes to high impedance, the software boost-mode bit clears, a status pulse fires, and a 3-bit fault code is latched. If several faults are active together, the code with the highest priority wins.

After a fault the supervisor either waits for software or retries on its own. It retries automatically only while the hardware restart enable is set and the external enable pin is active. The first restart comes a fixed delay after the fault. If the fault comes back during a retried run, each later restart uses a shorter repeat delay. Software can cancel the sequence at any time, either by clearing the fault field or by writing the mode bit to zero.

All timing counts ticks of a 1 µs prescaler taken from the system clock. The block also masks the modulator's switch request whenever the stage is off or the feedback comparator reports over-regulation.

Top module: `boost_fault_sup`

## Requirements
- R1: After reset, hiz=1, boost_en=0, mode_bit=0, fault_code=000, stat_pulse=0 and sw_req_out=0.
- R2: A strobe on wr_mode with wr_mode_val=1 sets mode_bit and starts the stage: boost_en=1 and hiz=0 from the next cycle. Register writes take precedence over a fault detected in the same cycle.
- R3: While the stage runs, a qualified fault has these effects from the next cycle: hiz=1, boost_en=0, mode_bit=0, and fault_code holds the code of that fault.
- R4: Fault codes are: 001 bus over-voltage, 010 soft-start failure or qualified current limit, 011 battery undervoltage, 101 thermal shutdown, 110 timer fault, and 000 for no fault.
- R5: When faults coincide, the code latched follows this priority, highest first: timer, thermal, over-voltage, undervoltage, current limit or soft-start.
- R6: Each fault entry drives stat_pulse high from the next cycle for STAT_TICKS ticks. A new fault entry during the pulse restarts its width.
- R7: Current limit becomes a fault only after flt_ilim and in_regulate have both been high, while running, for more than ILIM_TICKS consecutive ticks. A shorter or interrupted burst has no effect on fault_code or hiz.
- R8: Without restart permission (hw_otg_en=0 or otg_pin_active=0), the stage stays in high impedance after a fault until a mode write of 1 restarts it. If permission drops during a wait, the delay count is discarded.
- R9: With permission, the stage restarts FIRST_TICKS ticks after the fault. A fault occurring in a run that was started by a retry waits REPEAT_TICKS ticks instead.
- R10: A wr_fault_clr strobe, or a mode write of 0, sets fault_code to 000 and cancels any pending restart (the stage stays off). A wr_fault_clr while running leaves the stage running.
- R11: A timer fault (110) clears mode_bit and the retry history, and never restarts automatically.
- R12: sw_req_out equals sw_req_in only while boost_en=1 and fb_over_ref=0, and is 0 otherwise.
- R13: fault_code never takes the values 100 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_mode | input | 1 | Write strobe for the boost-mode bit |
| wr_mode_val | input | 1 | Value written to the boost-mode bit |
| wr_fault_clr | input | 1 | Write strobe clearing the fault field |
| hw_otg_en | input | 1 | Hardware restart enable |
| otg_pin_active | input | 1 | External enable pin, already at active level |
| flt_ovp | input | 1 | Bus over-voltage |
| flt_start | input | 1 | Soft-start failed to reach target |
| flt_ilim | input | 1 | Current limit active (raw) |
| flt_uvlo | input | 1 | Battery below boost undervoltage threshold |
| flt_therm | input | 1 | Thermal shutdown |
| flt_timer | input | 1 | Control timer expired |
| in_regulate | input | 1 | Stage is in its regulating phase |
| fb_over_ref | input | 1 | Feedback above reference |
| sw_req_in | input | 1 | Switch request from the modulator |
| mode_bit | output | 1 | Software boost-mode bit |
| boost_en | output | 1 | Power stage enabled |
| hiz | output | 1 | Power stage in high impedance |
| stat_pulse | output | 1 | Status pulse on fault |
| fault_code | output | 3 | Latched fault code |
| sw_req_out | output | 1 | Gated switch request |

## Verification
The bench builds the block with two system clocks per tick, a 5-tick current-limit qualifier, a 4-tick status pulse, a 20-tick first restart and a 15-tick repeat restart. With these values every fault class, several repeated retries, interrupted qualifier bursts and status-pulse retriggering fit into a few thousand cycles. They also keep both the tick alignment and the two separate retry delays visible. The reference model is compared on every cycle while faults persist, faults clear, and restart permission is removed in the middle of a wait.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_WAIT = 2'd2
   } bfs_state_t;

   typedef logic [2:0] fcode_t;

   // Code values are observed by software; positions are behaviour.
   localparam fcode_t FC_NONE  = 3'b000;
   localparam fcode_t FC_OVP   = 3'b001;
   localparam fcode_t FC_START = 3'b010;
   localparam fcode_t FC_UVLO  = 3'b011;
   localparam fcode_t FC_THERM = 3'b101;
   localparam fcode_t FC_TIMER = 3'b110;

   typedef struct packed {
      logic timer;
      logic therm;
      logic ovp;
      logic uvlo;
      logic start;
   } flt_vec_t;

endpackage

// File: rtl/bfs_tick.sv
module bfs_tick #(
   parameter int DIV = 250
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   if (DIV < 1) begin : g_bad_div
      $error("bfs_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      logic live_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) live_q <= 1'b0;
         else        live_q <= 1'b1;
      end
      assign tick = live_q;
   end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             pre_q <= '0;
         else if (pre_q == LAST) pre_q <= '0;
         else                    pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == LAST);
   end

endmodule

// File: rtl/bfs_ilim_qual.sv
module bfs_ilim_qual #(
   parameter int LIMIT = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic arm,
   output logic qual
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("bfs_ilim_qual: LIMIT must be at least 1");
   end

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TOP = CW'(LIMIT);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   run_q <= '0;
      else if (!arm)                run_q <= '0;
      else if (tick && run_q != TOP) run_q <= run_q + 1'b1;
   end

   // Sustained for more than LIMIT ticks: the next tick past a full count.
   assign qual = arm && tick && (run_q == TOP);

   // R7
   ilim_sustained_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qual |-> $past(arm));

endmodule

// File: rtl/bfs_fault_enc.sv
module bfs_fault_enc
   import bfs_pkg::*;
(
   input  flt_vec_t flt,
   input  logic     ilim_q,
   output fcode_t   code,
   output logic     any
);

   always_comb begin
      if (flt.timer)                  code = FC_TIMER;
      else if (flt.therm)             code = FC_THERM;
      else if (flt.ovp)               code = FC_OVP;
      else if (flt.uvlo)              code = FC_UVLO;
      else if (flt.start || ilim_q)   code = FC_START;
      else                            code = FC_NONE;
   end

   assign any = (code != FC_NONE);

   // R5
   timer_wins_chk: assert final (!flt.timer || code == FC_TIMER);

endmodule

// File: rtl/bfs_stat_pulse.sv
module bfs_stat_pulse #(
   parameter int WIDTH = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic trig,
   output logic pulse
);

   if (WIDTH < 1) begin : g_bad_width
      $error("bfs_stat_pulse: WIDTH must be at least 1");
   end

   localparam int CW = $clog2(WIDTH + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    left_q <= '0;
      else if (trig)                 left_q <= CW'(WIDTH);
      else if (tick && left_q != '0) left_q <= left_q - 1'b1;
   end

   assign pulse = (left_q != '0);

   // R6
   stat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse) |-> $past(trig));

endmodule

// File: rtl/boost_fault_sup.sv
module boost_fault_sup
   import bfs_pkg::*;
#(
   parameter int CLK_PER_US   = 250,
   parameter int ILIM_TICKS   = 50,
   parameter int STAT_TICKS   = 128,
   parameter int FIRST_TICKS  = 5200,
   parameter int REPEAT_TICKS = 5000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_mode,
   input  logic       wr_mode_val,
   input  logic       wr_fault_clr,
   input  logic       hw_otg_en,
   input  logic       otg_pin_active,
   input  logic       flt_ovp,
   input  logic       flt_start,
   input  logic       flt_ilim,
   input  logic       flt_uvlo,
   input  logic       flt_therm,
   input  logic       flt_timer,
   input  logic       in_regulate,
   input  logic       fb_over_ref,
   input  logic       sw_req_in,
   output logic       mode_bit,
   output logic       boost_en,
   output logic       hiz,
   output logic       stat_pulse,
   output logic [2:0] fault_code,
   output logic       sw_req_out
);

   if (FIRST_TICKS < 2 || REPEAT_TICKS < 1) begin : g_bad_retry
      $error("boost_fault_sup: retry delays too short");
   end

   localparam int RMAX = (FIRST_TICKS > REPEAT_TICKS) ? FIRST_TICKS : REPEAT_TICKS;
   localparam int RW   = $clog2(RMAX);

   bfs_state_t    st_q;
   logic          mode_q;
   fcode_t        code_q;
   logic [RW-1:0] rcnt_q;
   logic          retried_q;
   logic          locked_q;

   logic          tick;
   logic          ilim_arm;
   logic          ilim_q;
   flt_vec_t      flt;
   fcode_t        enc_code;
   logic          enc_any;
   logic          wr_any;
   logic          trig;
   logic          permit;
   logic [RW-1:0] rlast;

   bfs_tick #(.DIV(CLK_PER_US)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   assign ilim_arm = (st_q == ST_RUN) && in_regulate && flt_ilim;

   bfs_ilim_qual #(.LIMIT(ILIM_TICKS)) u_ilim (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .arm   (ilim_arm),
      .qual  (ilim_q)
   );

   assign flt = '{timer: flt_timer, therm: flt_therm, ovp: flt_ovp,
                  uvlo: flt_uvlo, start: flt_start};

   bfs_fault_enc u_enc (
      .flt    (flt),
      .ilim_q (ilim_q),
      .code   (enc_code),
      .any    (enc_any)
   );

   assign wr_any = wr_mode || wr_fault_clr;
   assign trig   = (st_q == ST_RUN) && enc_any && !wr_any;
   assign permit = hw_otg_en && otg_pin_active && !locked_q;
   assign rlast  = retried_q ? RW'(REPEAT_TICKS - 1) : RW'(FIRST_TICKS - 1);

   bfs_stat_pulse #(.WIDTH(STAT_TICKS)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .trig  (trig),
      .pulse (stat_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         mode_q    <= 1'b0;
         code_q    <= FC_NONE;
         rcnt_q    <= '0;
         retried_q <= 1'b0;
         locked_q  <= 1'b0;
      end else if (wr_mode) begin
         mode_q    <= wr_mode_val;
         rcnt_q    <= '0;
         retried_q <= 1'b0;
         locked_q  <= 1'b0;
         if (wr_mode_val) begin
            st_q <= ST_RUN;
         end else begin
            st_q   <= ST_IDLE;
            code_q <= FC_NONE;
         end
      end else if (wr_fault_clr) begin
         code_q <= FC_NONE;
         if (st_q == ST_WAIT) begin
            st_q      <= ST_IDLE;
            rcnt_q    <= '0;
            retried_q <= 1'b0;
            locked_q  <= 1'b0;
         end
      end else begin
         unique case (st_q)
            ST_RUN: begin
               if (enc_any) begin
                  st_q   <= ST_WAIT;
                  code_q <= enc_code;
                  mode_q <= 1'b0;
                  rcnt_q <= '0;
                  if (enc_code == FC_TIMER) begin
                     locked_q  <= 1'b1;
                     retried_q <= 1'b0;
                  end
               end
            end
            ST_WAIT: begin
               if (!permit) begin
                  rcnt_q <= '0;
               end else if (tick) begin
                  if (rcnt_q == rlast) begin
                     st_q      <= ST_RUN;
                     rcnt_q    <= '0;
                     retried_q <= 1'b1;
                  end else begin
                     rcnt_q <= rcnt_q + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign mode_bit   = mode_q;
   assign boost_en   = (st_q == ST_RUN);
   assign hiz        = !boost_en;
   assign fault_code = code_q;
   assign sw_req_out = sw_req_in && boost_en && !fb_over_ref;

   // R3
   fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_RUN) && enc_any && !wr_any)
         |=> (hiz && !mode_bit && fault_code == $past(enc_code)));

   // R13
   code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_code != 3'b100) && (fault_code != 3'b111));

   // R10
   clear_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_mode && !wr_mode_val) || (wr_fault_clr && !wr_mode))
         |=> (fault_code == FC_NONE));

   // R8
   no_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_WAIT) && !(hw_otg_en && otg_pin_active) && !wr_mode) |=> hiz);

   // R11
   timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_WAIT) && (fault_code == FC_TIMER) && !wr_mode) |=> hiz);

   // R9
   retry_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(boost_en) && !$past(wr_mode)) |-> $past(tick));

endmodule

// File: tb/sim_boost_fault_sup.sv
module sim_boost_fault_sup;

   localparam int CPU   = 2;
   localparam int CLT   = 5;
   localparam int STT   = 4;
   localparam int FST   = 20;
   localparam int RPT   = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_mode = 0, wr_mode_val = 0, wr_fault_clr = 0;
   logic hw_otg_en = 0, otg_pin_active = 0;
   logic flt_ovp = 0, flt_start = 0, flt_ilim = 0, flt_uvlo = 0, flt_therm = 0, flt_timer = 0;
   logic in_regulate = 0, fb_over_ref = 0, sw_req_in = 0;
   logic mode_bit, boost_en, hiz, stat_pulse, sw_req_out;
   logic [2:0] fault_code;

   always #2 clk = ~clk;

   boost_fault_sup #(
      .CLK_PER_US(CPU), .ILIM_TICKS(CLT), .STAT_TICKS(STT),
      .FIRST_TICKS(FST), .REPEAT_TICKS(RPT)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wr_mode_val(wr_mode_val),
      .wr_fault_clr(wr_fault_clr), .hw_otg_en(hw_otg_en), .otg_pin_active(otg_pin_active),
      .flt_ovp(flt_ovp), .flt_start(flt_start), .flt_ilim(flt_ilim), .flt_uvlo(flt_uvlo),
      .flt_therm(flt_therm), .flt_timer(flt_timer), .in_regulate(in_regulate),
      .fb_over_ref(fb_over_ref), .sw_req_in(sw_req_in), .mode_bit(mode_bit),
      .boost_en(boost_en), .hiz(hiz), .stat_pulse(stat_pulse), .fault_code(fault_code),
      .sw_req_out(sw_req_out)
   );

   // Behavioural reference: running=1 means the stage is on.
   int running = 0, waiting = 0, m_mode = 0, m_code = 0;
   int delay_left = 0, after_retry = 0, timer_lock = 0;
   int prescale = 0, ilim_run = 0, stat_left = 0;

   int vectors = 0, bad = 0;
   string cur_req = "R1";
   bit done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         running = 0; waiting = 0; m_mode = 0; m_code = 0; delay_left = 0;
         after_retry = 0; timer_lock = 0; prescale = 0; ilim_run = 0; stat_left = 0;
      end else begin
         bit t, armed, qual, entry, allow;
         int c;
         t = (prescale == CPU - 1);
         prescale = t ? 0 : prescale + 1;
         armed = running && in_regulate && flt_ilim;
         qual = armed && t && (ilim_run == CLT);
         if (flt_timer) c = 6;
         else if (flt_therm) c = 5;
         else if (flt_ovp) c = 1;
         else if (flt_uvlo) c = 3;
         else if (flt_start || qual) c = 2;
         else c = 0;
         entry = running && (c != 0) && !wr_mode && !wr_fault_clr;
         if (entry) stat_left = STT;
         else if (t && stat_left > 0) stat_left--;
         if (!armed) ilim_run = 0;
         else if (t && ilim_run < CLT) ilim_run++;
         allow = hw_otg_en && otg_pin_active && !timer_lock;
         if (wr_mode) begin
            m_mode = wr_mode_val; after_retry = 0; timer_lock = 0; waiting = 0;
            running = wr_mode_val;
            if (!wr_mode_val) m_code = 0;
         end else if (wr_fault_clr) begin
            m_code = 0;
            if (waiting) begin waiting = 0; after_retry = 0; timer_lock = 0; end
         end else if (entry) begin
            running = 0; waiting = 1; m_code = c; m_mode = 0;
            delay_left = after_retry ? RPT : FST;
            if (c == 6) begin timer_lock = 1; after_retry = 0; end
         end else if (waiting) begin
            if (!allow) delay_left = after_retry ? RPT : FST;
            else if (t) begin
               delay_left--;
               if (delay_left == 0) begin waiting = 0; running = 1; after_retry = 1; end
            end
         end
         if (entry || (waiting && !allow)) delay_left = after_retry ? RPT : FST;
      end
   end

   task automatic cmp(string nm, int act, int exp);
      vectors++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: got %0d expected %0d at %0t", cur_req, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         cmp("hiz", hiz, running ? 0 : 1);
         cmp("boost_en", boost_en, running);
         cmp("mode_bit", mode_bit, m_mode);
         cmp("fault_code", fault_code, m_code);
         cmp("stat_pulse", stat_pulse, stat_left > 0);
         cmp("sw_req_out", sw_req_out, sw_req_in && running && !fb_over_ref);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wmode(bit v);
      @(posedge clk); #1; wr_mode = 1; wr_mode_val = v;
      @(posedge clk); #1; wr_mode = 0; wr_mode_val = 0;
   endtask

   task automatic wclr();
      @(posedge clk); #1; wr_fault_clr = 1;
      @(posedge clk); #1; wr_fault_clr = 0;
   endtask

   task automatic clear_faults();
      flt_ovp = 0; flt_start = 0; flt_ilim = 0; flt_uvlo = 0; flt_therm = 0; flt_timer = 0;
   endtask

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         bad++;
         $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
         $finish;
      end
   end

   initial begin
      cur_req = "R1";
      cyc(4);
      rst_n = 1;
      cyc(3);

      cur_req = "R2";
      wmode(1); cyc(4);
      cur_req = "R12";
      sw_req_in = 1; cyc(3); fb_over_ref = 1; cyc(3); fb_over_ref = 0; cyc(2); sw_req_in = 0;

      cur_req = "R4";
      flt_ovp = 1; cyc(2); flt_ovp = 0; cyc(12); wclr(); wmode(1); cyc(2);
      flt_start = 1; cyc(1); flt_start = 0; cyc(12); wclr(); wmode(1); cyc(2);
      flt_uvlo = 1; cyc(3); flt_uvlo = 0; cyc(12); wclr(); wmode(1); cyc(2);
      cur_req = "R3";
      flt_therm = 1; cyc(1); flt_therm = 0; cyc(12); wclr(); wmode(1); cyc(2);

      cur_req = "R5";
      flt_ovp = 1; flt_uvlo = 1; flt_start = 1; cyc(1); clear_faults(); cyc(10); wmode(1);
      flt_uvlo = 1; flt_start = 1; cyc(1); clear_faults(); cyc(10); wmode(1);
      flt_therm = 1; flt_ovp = 1; cyc(1); clear_faults(); cyc(10); wmode(1);
      flt_timer = 1; flt_therm = 1; cyc(1); clear_faults(); cyc(10); wclr(); wmode(1);

      cur_req = "R7";
      in_regulate = 1;
      for (int k = 0; k < 6; k++) begin flt_ilim = 1; cyc(2 * CLT - 1 + (k % 2)); flt_ilim = 0; cyc(1); end
      flt_ilim = 1; in_regulate = 0; cyc(30); in_regulate = 1; cyc(30);
      flt_ilim = 0; cyc(10); wclr();

      cur_req = "R6";
      wmode(1); flt_uvlo = 1; cyc(1); flt_uvlo = 0; cyc(3); wmode(1); flt_ovp = 1; cyc(1); flt_ovp = 0;
      cyc(20);

      cur_req = "R8";
      hw_otg_en = 0; otg_pin_active = 1; cyc(80);
      wmode(1); cyc(4);

      cur_req = "R9";
      hw_otg_en = 1; flt_ovp = 1; cyc(2 * (FST + 3 * RPT) + 7); flt_ovp = 0;
      cyc(2 * (RPT + 4)); cyc(10);
      flt_uvlo = 1; cyc(1); flt_uvlo = 0; cyc(2 * RPT + 10);
      cur_req = "R8";
      flt_therm = 1; cyc(1); flt_therm = 0; cyc(15); otg_pin_active = 0; cyc(60);
      otg_pin_active = 1; cyc(2 * FST + 10);

      cur_req = "R10";
      wmode(1); flt_ovp = 1; cyc(1); flt_ovp = 0; cyc(10); wclr(); cyc(2 * FST + 10);
      wmode(1); flt_uvlo = 1; cyc(1); flt_uvlo = 0; cyc(10); wmode(0); cyc(2 * FST + 10);
      wmode(1); cyc(3); wclr(); cyc(5);

      cur_req = "R11";
      flt_timer = 1; cyc(1); flt_timer = 0; cyc(2 * FST + 40);
      wmode(1); cyc(5);

      cur_req = "R13";
      flt_start = 1; flt_timer = 1; cyc(1); clear_faults(); cyc(8); wmode(0); cyc(4);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
   end

endmodule